// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver with Polarity Select

This block is a master-side synchronous serial port. A single start strobe loads an 8-bit word. The block then makes its own serial clock and moves the word out on a transmit line. In the same transfer it collects an 8-bit word from a receive line, one bit per clock period. When the last bit has been taken in, the received word appears on a parallel read port and a one-cycle done strobe is raised.

One polarity control sets two things together: the level the serial clock rests at, and which clock edge launches transmit data while the other samples receive data. Two further controls choose between least-significant-bit-first and most-significant-bit-first order, and invert the data level on both serial lines. An 8-bit divisor sets the serial bit rate. All three controls and the divisor are captured when a transfer starts and are held until it ends. A start strobe that arrives while a transfer is running has no effect.

Top module: `ssx_xcvr`

## Requirements
- R1: Each accepted start performs one full-duplex exchange of exactly 8 bits. The serial clock makes exactly 16 transitions: 8 launch edges, each driving one transmit bit, and 8 sample edges, each capturing one receive bit.
- R2: Outside a transfer, `sclk` rests at the inverse of `cfg_pol`: high when `cfg_pol`=0 and low when `cfg_pol`=1. After reset `sclk` is high.
- R3: With `cfg_pol`=0, `txd` changes on falling edges of `sclk` and `rxd` is taken on rising edges. With `cfg_pol`=1, `txd` changes on rising edges and `rxd` is taken on falling edges.
- R4: With `cfg_msb_first`=0, bit 0 of `tx_data` is sent first and the first received bit lands in bit 0 of `rx_data`. With `cfg_msb_first`=1, bit 7 is sent first and the first received bit lands in bit 7.
- R5: With `cfg_invert`=1, the level driven on `txd` is the complement of the data bit, and the data bit stored from `rxd` is the complement of the level on the line. With `cfg_invert`=0, no level is changed.
- R6: Each half period of `sclk` lasts `div`+1 system clocks. The first clock transition, which is a launch edge, comes `div`+1 cycles after the cycle in which start is accepted. `done` rises 16*(`div`+1)+1 cycles after the accepting cycle.
- R7: `done` is high for exactly one cycle. `busy` falls in that same cycle. `rx_data` then keeps the received word until the next completed transfer.
- R8: A start strobe while `busy`=1 is ignored. The running transfer keeps its data, timing and length.
- R9: `cfg_pol`, `cfg_msb_first`, `cfg_invert` and `div` are captured when start is accepted. Changing them during a transfer has no effect on it.
- R10: During a transfer, `txd` holds each bit steady from its launch edge through the following sample edge. Outside a transfer, `txd` rests high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe; accepted only while not busy |
| tx_data | input | 8 | Word to transmit, captured at start |
| cfg_pol | input | 1 | Clock polarity: 0 = idle high, launch on fall; 1 = idle low, launch on rise |
| cfg_msb_first | input | 1 | Bit order: 0 = LSB first, 1 = MSB first |
| cfg_invert | input | 1 | 1 = invert serial data levels on both lines |
| div | input | 8 | Half period of the serial clock minus one, in system clocks |
| rx_data | output | 8 | Last received word |
| done | output | 1 | One-cycle strobe when `rx_data` is updated |
| busy | output | 1 | High while a transfer is running |
| sclk | output | 1 | Serial clock output |
| txd | output | 1 | Serial transmit data |
| rxd | input | 1 | Serial receive data |

## Verification
A directed sweep drives all eight combinations of polarity, bit order and inversion with the fastest divisor. It uses asymmetric word pairs such as 0xA5/0x3C, 0x81/0x7E and 0x00/0xFF, so that a reversed bit order, a missing inversion or a swapped edge pairing each produce a different wrong word. Random transfers then vary the words, the controls and small divisors, which shows that the half-period timing and the done latency scale with the divisor. In some transfers a second start, a new divisor and flipped controls are applied in the middle. The first transfer's words, edge count and timing must still come out unchanged, which separates an ignored restart and properly held controls from a design that reloads.

// File: rtl/ssx_pkg.sv
package ssx_pkg;

  typedef struct packed {
    logic pol;
    logic msb;
    logic inv;
  } ssx_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } ssx_state_e;

endpackage

// File: rtl/ssx_baud.sv
module ssx_baud #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [DIVW-1:0] div,
  output logic            tick
);

  logic [DIVW-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt == div) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + DIVW'(1);
    end
  end

  // half-period counter never runs past the held divisor (R6)
  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
    run && $past(run) && $stable(div) |-> cnt <= div);

endmodule

// File: rtl/ssx_ctrl.sv
module ssx_ctrl
  import ssx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic tick,
  input  logic pol_in,
  input  logic pol_q,
  output logic sclk,
  output logic busy,
  output logic done,
  output logic run,
  output logic launch,
  output logic sample,
  output logic fin
);

  localparam int EDGES = 2 * DW;
  localparam int EW    = $clog2(EDGES + 1);

  ssx_state_e    state;
  logic [EW-1:0] edge_cnt;
  logic          last_edge;

  assign run       = (state == ST_RUN);
  assign fin       = (state == ST_FIN);
  assign launch    = run && tick && !edge_cnt[0];
  assign sample    = run && tick &&  edge_cnt[0];
  assign last_edge = sample && (edge_cnt == EW'(EDGES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      edge_cnt <= '0;
      sclk     <= 1'b1;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          sclk <= ~pol_in;
          if (accept) begin
            state    <= ST_RUN;
            busy     <= 1'b1;
            edge_cnt <= '0;
          end
        end
        ST_RUN: begin
          if (tick) begin
            sclk     <= ~sclk;
            edge_cnt <= edge_cnt + EW'(1);
            if (last_edge) begin
              state <= ST_FIN;
            end
          end
        end
        ST_FIN: begin
          sclk  <= ~pol_q;
          busy  <= 1'b0;
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: begin
          state <= ST_IDLE;
          busy  <= 1'b0;
        end
      endcase
    end
  end

  // idle clock level follows the polarity input (R2)
  assert_idle_level_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && state == ST_IDLE && $past(state) == ST_IDLE |-> sclk == ~$past(pol_in));

  // the clock is back at idle level when the transfer finishes (R3)
  assert_end_level_R3: assert property (@(posedge clk) disable iff (rst)
    fin |-> sclk == ~pol_q);

  // done is a single-cycle strobe (R7)
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // busy is already clear while done is high (R7)
  assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // the edge count stays within one transfer (R1)
  assert_edge_bound_R1: assert property (@(posedge clk) disable iff (rst)
    edge_cnt <= EW'(EDGES));

endmodule

// File: rtl/ssx_shift.sv
module ssx_shift
  import ssx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] tx_word,
  input  ssx_cfg_t      cfg,
  input  logic          launch,
  input  logic          sample,
  input  logic          fin,
  input  logic          rxd,
  output logic          txd,
  output logic [DW-1:0] rx_word
);

  logic [DW-1:0] tx_sr;
  logic [DW-1:0] rx_sr;
  logic          tx_bit;
  logic          rx_bit;

  assign tx_bit = (cfg.msb ? tx_sr[DW-1] : tx_sr[0]) ^ cfg.inv;
  assign rx_bit = rxd ^ cfg.inv;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr <= '0;
    end else if (load) begin
      tx_sr <= tx_word;
    end else if (launch) begin
      if (cfg.msb) begin
        tx_sr <= {tx_sr[DW-2:0], 1'b0};
      end else begin
        tx_sr <= {1'b0, tx_sr[DW-1:1]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txd <= 1'b1;
    end else if (launch) begin
      txd <= tx_bit;
    end else if (fin) begin
      txd <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_sr <= '0;
    end else if (load) begin
      rx_sr <= '0;
    end else if (sample) begin
      if (cfg.msb) begin
        rx_sr <= {rx_sr[DW-2:0], rx_bit};
      end else begin
        rx_sr <= {rx_bit, rx_sr[DW-1:1]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_word <= '0;
    end else if (fin) begin
      rx_word <= rx_sr;
    end
  end

  // txd moves only at a launch edge or on the return to idle (R10)
  assert_txd_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$stable(txd) |-> $past(launch) || $past(fin));

  // the read port changes only when a transfer completes (R7)
  assert_rx_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(fin) |-> $stable(rx_word));

endmodule

// File: rtl/ssx_xcvr.sv
module ssx_xcvr
  import ssx_pkg::*;
#(
  parameter int DW   = 8,
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [DW-1:0]   tx_data,
  input  logic            cfg_pol,
  input  logic            cfg_msb_first,
  input  logic            cfg_invert,
  input  logic [DIVW-1:0] div,
  output logic [DW-1:0]   rx_data,
  output logic            done,
  output logic            busy,
  output logic            sclk,
  output logic            txd,
  input  logic            rxd
);

  ssx_cfg_t        cfg_q;
  logic [DIVW-1:0] div_q;
  logic            accept;
  logic            tick;
  logic            run;
  logic            launch;
  logic            sample;
  logic            fin;

  assign accept = start && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      div_q <= '0;
    end else if (accept) begin
      cfg_q <= '{pol: cfg_pol, msb: cfg_msb_first, inv: cfg_invert};
      div_q <= div;
    end
  end

  ssx_baud #(.DIVW(DIVW)) u_baud (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .div  (div_q),
    .tick (tick)
  );

  ssx_ctrl #(.DW(DW)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .accept (accept),
    .tick   (tick),
    .pol_in (cfg_pol),
    .pol_q  (cfg_q.pol),
    .sclk   (sclk),
    .busy   (busy),
    .done   (done),
    .run    (run),
    .launch (launch),
    .sample (sample),
    .fin    (fin)
  );

  ssx_shift #(.DW(DW)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .tx_word (tx_data),
    .cfg     (cfg_q),
    .launch  (launch),
    .sample  (sample),
    .fin     (fin),
    .rxd     (rxd),
    .txd     (txd),
    .rx_word (rx_data)
  );

  // a start during a transfer reloads nothing (R8)
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    busy && start |=> $stable(cfg_q) && $stable(div_q));

  // held controls stay fixed for the whole transfer (R9)
  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (rst)
    $past(busy) && busy |-> $stable(cfg_q) && $stable(div_q));

  // a launch edge of the held polarity drives sclk toward its non-idle level (R3)
  assert_launch_dir_R3: assert property (@(posedge clk) disable iff (rst)
    launch |=> sclk == cfg_q.pol);

endmodule

// File: tb/tb_ssx_xcvr.sv
module tb_ssx_xcvr;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] tx_data = '0;
  logic       cfg_pol = 1'b0;
  logic       cfg_msb_first = 1'b0;
  logic       cfg_invert = 1'b0;
  logic [7:0] div = '0;
  logic [7:0] rx_data;
  logic       done;
  logic       busy;
  logic       sclk;
  logic       txd;
  logic       rxd = 1'b1;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  ssx_xcvr dut (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .tx_data       (tx_data),
    .cfg_pol       (cfg_pol),
    .cfg_msb_first (cfg_msb_first),
    .cfg_invert    (cfg_invert),
    .div           (div),
    .rx_data       (rx_data),
    .done          (done),
    .busy          (busy),
    .sclk          (sclk),
    .txd           (txd),
    .rxd           (rxd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic line_bit(input logic [7:0] w, input int b,
                                    input logic m, input logic iv);
    return (m ? w[7-b] : w[b]) ^ iv;
  endfunction

  function automatic int done_latency(input logic [7:0] dv);
    return 16 * (int'(dv) + 1) + 2;
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 200000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  task automatic xfer(input logic [7:0] d, input logic [7:0] w, input logic p,
                      input logic m, input logic iv, input logic [7:0] dv,
                      input bit spam);
    int h;
    int n;
    int k;
    int last_n;
    logic prev;
    logic cur_bit;
    logic [7:0] txcap;
    logic [7:0] act_tx;
    int bad_dir;
    int bad_gap;
    int bad_hold;
    h = int'(dv) + 1;
    n = 0; k = 0; last_n = 1;
    txcap = '0; bad_dir = 0; bad_gap = 0; bad_hold = 0; cur_bit = 1'b1;
    @(negedge clk);
    tx_data = d; cfg_pol = p; cfg_msb_first = m; cfg_invert = iv; div = dv;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    check(busy == 1'b1, "R1", "busy after start", busy, 1);
    check(sclk == ~p, "R2", "sclk rests before first edge", sclk, ~p);
    prev = sclk;
    while (!done && n < done_latency(dv) + 8) begin
      if (sclk != prev) begin
        k++;
        if (n - last_n != h) bad_gap++;
        if (k % 2 == 1) begin
          if (sclk != p) bad_dir++;
          if (k <= 15) begin
            txcap[(k-1)/2] = txd;
            cur_bit = txd;
            rxd = line_bit(w, (k-1)/2, m, iv);
          end
        end else begin
          if (sclk != ~p) bad_dir++;
          if (txd != cur_bit) bad_hold++;
        end
        prev = sclk;
        last_n = n;
      end
      if (spam && n == 3) begin
        start = 1'b1;
        tx_data = ~d;
        cfg_pol = ~p; cfg_msb_first = ~m; cfg_invert = ~iv;
        div = dv + 8'd3;
      end
      if (spam && n == 4) start = 1'b0;
      @(negedge clk);
      n++;
    end
    check(n == done_latency(dv), spam ? "R8" : "R6", "done latency", n, done_latency(dv));
    check(k == 16, "R1", "sclk transitions", k, 16);
    check(bad_gap == 0, "R6", "half periods off", bad_gap, 0);
    check(bad_dir == 0, "R3", "wrong edge direction", bad_dir, 0);
    check(bad_hold == 0, "R10", "txd moved before sample edge", bad_hold, 0);
    act_tx = '0;
    for (int b = 0; b < 8; b++) begin
      if (m) act_tx[7-b] = txcap[b] ^ iv;
      else   act_tx[b]   = txcap[b] ^ iv;
    end
    check(act_tx == d, spam ? "R9" : (iv ? "R5" : "R4"), "transmitted word", act_tx, d);
    check(rx_data == w, spam ? "R9" : (m ? "R4" : "R5"), "received word", rx_data, w);
    check(busy == 1'b0, "R7", "busy with done", busy, 0);
    check(sclk == ~p, "R2", "sclk idle at done", sclk, ~p);
    cfg_pol = p; cfg_msb_first = m; cfg_invert = iv; div = dv; tx_data = d;
    @(negedge clk);
    check(done == 1'b0, "R7", "done second cycle", done, 0);
    check(rx_data == w, "R7", "rx_data held", rx_data, w);
    check(txd == 1'b1, "R10", "txd idle", txd, 1);
    check(busy == 1'b0, "R8", "no restart from ignored start", busy, 0);
  endtask

  initial begin
    logic [7:0] pat_d [3];
    logic [7:0] pat_w [3];
    int unsigned seed_val;
    seed_val = $urandom(32'd20240611);
    pat_d[0] = 8'hA5; pat_w[0] = 8'h3C;
    pat_d[1] = 8'h81; pat_w[1] = 8'h7E;
    pat_d[2] = 8'h00; pat_w[2] = 8'hFF;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0, "R7", "reset busy", busy, 0);
    check(done == 1'b0, "R7", "reset done", done, 0);
    check(txd == 1'b1, "R10", "reset txd", txd, 1);
    check(sclk == 1'b1, "R2", "reset sclk", sclk, 1);
    check(rx_data == 8'h00, "R7", "reset rx_data", rx_data, 0);

    cfg_pol = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(sclk == 1'b0, "R2", "idle sclk with pol=1", sclk, 0);
    cfg_pol = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(sclk == 1'b1, "R2", "idle sclk with pol=0", sclk, 1);

    for (int c = 0; c < 8; c++) begin
      xfer(pat_d[c % 3], pat_w[c % 3], c[0], c[1], c[2], 8'd0, 1'b0);
    end
    xfer(8'h5A, 8'hC3, 1'b0, 1'b0, 1'b0, 8'd2, 1'b1);
    xfer(8'h96, 8'h69, 1'b1, 1'b1, 1'b1, 8'd1, 1'b1);

    for (int i = 0; i < 40; i++) begin
      logic [7:0] rd;
      logic [7:0] rw;
      logic [2:0] rc;
      logic [7:0] rdv;
      rd  = 8'($urandom);
      rw  = 8'($urandom);
      rc  = 3'($urandom);
      rdv = 8'($urandom % 4);
      xfer(rd, rw, rc[0], rc[1], rc[2], rdv, ($urandom % 4) == 0);
    end

    xfer(8'hF0, 8'h0F, 1'b1, 1'b0, 1'b0, 8'd7, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule